// File: doc/BRIEF.md
# Receive Byte Queue with Overrun Control

This block buffers the characters produced by a serial receiver until a host processor collects them. Each character arrives as a one-cycle strobe carrying a byte. Accepted bytes enter a first-in first-out store whose capacity is set by a control bit to half or all of its storage. The host reaches the block through a small register port with five addresses: status, data, control, queue status and fill count.

A programmable threshold drives a request line that can serve as an interrupt or as a DMA trigger. It is high while the fill count is at or above the threshold. If a byte arrives when the queue is full, the byte is dropped and the stored bytes stay as they are. The drop sets a sticky overrun bit in the main status register and a sticky overflow bit in the queue status register. The overrun bit clears in only two ways: the host reads the status register while the bit is set and then reads the data register, or the host turns the receiver off. The overflow bit and an underflow bit are write-one-to-clear. A flush command empties the queue in one cycle.

Register map: address 0 is status (bit0 overrun, bit1 empty, bit2 request). Address 1 is data. Address 2 is control (bit0 receiver on, bit1 deep mode, bit2 underflow interrupt enable, bit3 flush pulse that reads back as 0, bits 7:4 threshold). Address 3 is queue status (bit0 overflow, bit1 underflow). Address 4 is the fill count. A read returns data in the same cycle it is presented, and its side effects take place at the clock edge that ends the read.

Top module: `rxq_ctrl`

## Requirements
- R1: After reset the receiver is off, deep mode is on, the threshold is 1, the fill count is 0, status reads 8'h02, queue status reads 8'h00, and both request outputs are low.
- R2: Accepted bytes are read from address 1 in arrival order. The fill count at address 4 equals the bytes accepted minus the bytes read, and status bit1 is 1 exactly when the count is 0.
- R3: With control bit1 at 0 the queue holds 8 bytes. With control bit1 at 1 it holds 16 bytes.
- R4: A byte that arrives while the queue is full is discarded, and the bytes already stored are read back unchanged.
- R5: A discarded byte sets status bit0 (overrun) and queue status bit0 (overflow). Both bits stay set.
- R6: The overrun bit clears only when a data read follows a status read made while the bit was set. A data read with no such status read leaves it set. Each data read from a non-empty queue takes exactly one byte.
- R7: Writing control bit0 as 0 clears the overrun bit at that write.
- R8: While control bit0 is 0, strobes on the byte input leave the queue, the count and every flag unchanged.
- R9: The request output is high exactly when the fill count is at least control bits 7:4. A threshold of 1 raises it for one stored byte.
- R10: Writing control with bit3 set empties the queue, and the count reads 0 afterwards.
- R11: A data read from an empty queue sets queue status bit1, leaves the count at 0 and returns the last byte read. The underflow interrupt output equals that bit ANDed with control bit2.
- R12: Writing 1 to bit0 or bit1 of queue status clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid during the read cycle |
| fill_req | output | 1 | Threshold request for an interrupt or DMA |
| uf_irq | output | 1 | Underflow interrupt |

## Verification
A read pointer that moved by more or less than one entry would show up at once. The data read in the overrun-clear handshake would return the wrong byte, or the fill count read next would be wrong. A dropped byte that was written anyway would appear as a changed stored byte during the drain that follows. A handshake flag armed or cleared at the wrong moment would leave the overrun bit wrong on the next status read, one cycle after the data read. A threshold comparison that is off by one would first show when the count crosses the programmed value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [2:0] {
    RA_STAT  = 3'd0,
    RA_DATA  = 3'd1,
    RA_CTRL  = 3'd2,
    RA_FSTAT = 3'd3,
    RA_COUNT = 3'd4
  } reg_addr_e;

  // control register: threshold in the high nibble, flush pulse, irq enable, depth, receiver on
  typedef struct packed {
    logic [3:0] wm;
    logic       flush;
    logic       uf_ie;
    logic       deep;
    logic       en;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{wm: 4'd1, flush: 1'b0, uf_ie: 1'b0, deep: 1'b1, en: 1'b0};

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic          deep,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] CAP_HI = PW'(DEPTH);
  localparam logic [PW-1:0] CAP_LO = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] cap_of(input logic d);
    return d ? CAP_HI : CAP_LO;
  endfunction

  function automatic logic [PW-1:0] fill_of(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          wr_fire, rd_fire;

  assign count   = fill_of(wr_ptr, rd_ptr);
  assign full    = count >= cap_of(deep);
  assign empty   = (count == '0);
  assign wr_fire = push && !full && !flush;
  assign rd_fire = pop && !empty && !flush;
  assign head    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      rd_ptr <= wr_ptr;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  a_r4_full_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> count == $past(count));
  a_r6_pop_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !empty && !push && !flush |=> count == $past(count) - 1'b1);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP_HI);

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic rx_off,
  input  logic under,
  input  logic w1c_ovf,
  input  logic w1c_udf,
  output logic ovr,
  output logic ovf,
  output logic udf
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr   <= 1'b0;
      armed <= 1'b0;
      ovf   <= 1'b0;
      udf   <= 1'b0;
    end else begin
      // overrun: disabling the receiver wins, then a new drop, then the handshake
      if (rx_off)                  ovr <= 1'b0;
      else if (drop)               ovr <= 1'b1;
      else if (data_rd && armed)   ovr <= 1'b0;

      if (rx_off || data_rd)       armed <= 1'b0;
      else if (stat_rd && ovr)     armed <= 1'b1;

      if (drop)                    ovf <= 1'b1;
      else if (w1c_ovf)            ovf <= 1'b0;

      if (under)                   udf <= 1'b1;
      else if (w1c_udf)            udf <= 1'b0;
    end
  end

  a_r5_drop_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !rx_off |=> ovr && ovf);
  a_r6_plain_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && data_rd && !armed && !rx_off |=> ovr);
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_off |=> !ovr);
  a_r11_under_sets: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> udf);
  a_r12_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_ovf && !drop |=> !ovf);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          fill_req,
  output logic          uf_irq
);
  import rxq_pkg::*;

  localparam int PW = AW + 1;

  ctrl_t         ctrl_q, ctrl_in;
  logic [DW-1:0] head, last_rd;
  logic [PW-1:0] count;
  logic          full, empty, ovr, ovf, udf;

  // named events shared by the submodules and the assertions
  logic stat_rd, data_rd, ctrl_wr, fstat_wr;
  logic rx_take, drop, under, flush_now, rx_off;

  assign ctrl_in   = ctrl_t'(reg_wdata);
  assign stat_rd   = reg_rd && (reg_addr == RA_STAT);
  assign data_rd   = reg_rd && (reg_addr == RA_DATA);
  assign ctrl_wr   = reg_wr && (reg_addr == RA_CTRL);
  assign fstat_wr  = reg_wr && (reg_addr == RA_FSTAT);
  assign rx_take   = rx_valid && ctrl_q.en;
  assign drop      = rx_take && full;
  assign under     = data_rd && empty;
  assign flush_now = ctrl_wr && ctrl_in.flush;
  assign rx_off    = ctrl_wr && !ctrl_in.en;

  rxq_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(rx_take), .pop(data_rd), .flush(flush_now),
    .deep(ctrl_q.deep), .din(rx_byte), .head(head), .count(count),
    .full(full), .empty(empty)
  );

  rxq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .drop(drop), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_off(rx_off), .under(under), .w1c_ovf(fstat_wr && reg_wdata[0]),
    .w1c_udf(fstat_wr && reg_wdata[1]), .ovr(ovr), .ovf(ovf), .udf(udf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      last_rd <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q       <= ctrl_in;
        ctrl_q.flush <= 1'b0;
      end
      if (data_rd && !empty) last_rd <= head;
    end
  end

  assign fill_req = count >= PW'(ctrl_q.wm);
  assign uf_irq   = udf && ctrl_q.uf_ie;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STAT:  reg_rdata = {5'b0, fill_req, empty, ovr};
      RA_DATA:  reg_rdata = 8'(empty ? last_rd : head);
      RA_CTRL:  reg_rdata = ctrl_q;
      RA_FSTAT: reg_rdata = {6'b0, udf, ovf};
      RA_COUNT: reg_rdata = 8'(count);
      default:  reg_rdata = '0;
    endcase
  end

  a_r8_disabled_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !ctrl_q.en && !reg_rd && !reg_wr |=> $stable(count) && $stable(ovr) && $stable(ovf));
  a_r11_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    under && !rx_take && !flush_now |=> count == '0);

endmodule

// File: tb/sim_rxq_ctrl.sv
module sim_rxq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       fill_req, uf_irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_rd = 8'h00;
  bit  m_en = 1'b0;
  int  m_cap = 16;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fill_req(fill_req), .uf_irq(uf_irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 3'd2) begin
      m_en  = d[0];
      m_cap = d[1] ? 16 : 8;
      if (d[3]) exp_q.delete();
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  // driver: sends a byte and pushes the expected item when the model accepts it
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    if (m_en && exp_q.size() < m_cap) exp_q.push_back(b);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  // monitor: takes the oldest expected item and compares it with the data read
  task automatic take(input string req);
    logic [7:0] d, e;
    rd(3'd1, d);
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else e = last_rd;
    last_rd = e;
    check(req, d, e);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); check("R1 status", d, 8'h02);
    rd(3'd4, d); check("R1 count", d, 8'h00);
    rd(3'd3, d); check("R1 fstat", d, 8'h00);
    check("R1 outputs", {6'b0, fill_req, uf_irq}, 8'h00);

    // R8 receiver off
    send(8'h55);
    rd(3'd4, d); check("R8 count unchanged", d, 8'h00);
    rd(3'd3, d); check("R8 flags unchanged", d, 8'h00);

    // R2 order and count, R9 threshold 1
    wr(3'd2, 8'h13);
    send(8'h31); send(8'h32); send(8'h33);
    rd(3'd4, d); check("R2 count", d, 8'h03);
    check("R9 threshold 1", {7'b0, fill_req}, 8'h01);
    take("R2 order"); take("R2 order"); take("R2 order");
    rd(3'd0, d); check("R2 empty", d, 8'h02);

    // R9 threshold 4
    wr(3'd2, 8'h43);
    send(8'h01); send(8'h02); send(8'h03);
    check("R9 below threshold", {7'b0, fill_req}, 8'h00);
    send(8'h04);
    check("R9 at threshold", {7'b0, fill_req}, 8'h01);
    for (int i = 0; i < 4; i++) take("R2 drain");

    // R3 shallow depth, R4 drop, R5 flags, R6 handshake
    wr(3'd2, 8'h11);
    for (int i = 0; i < 10; i++) send(8'hA0 + 8'(i));
    rd(3'd4, d); check("R3 shallow capacity", d, 8'h08);
    rd(3'd3, d); check("R5 overflow bit", d, 8'h01);
    take("R4 oldest kept");
    rd(3'd0, d); check("R6 plain read keeps overrun", d, 8'h05);
    take("R6 handshake read");
    rd(3'd0, d); check("R6 overrun cleared", d, 8'h04);
    rd(3'd4, d); check("R6 one entry per read", d, 8'h06);
    for (int i = 0; i < 6; i++) take("R4 stored bytes");

    // R12 write one to clear
    rd(3'd3, d); check("R12 overflow still set", d, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd3, d); check("R12 overflow cleared", d, 8'h00);

    // R11 underflow
    take("R11 returns last byte");
    rd(3'd3, d); check("R11 underflow bit", d, 8'h02);
    rd(3'd4, d); check("R11 count stays 0", d, 8'h00);
    check("R11 irq masked", {7'b0, uf_irq}, 8'h00);
    wr(3'd2, 8'h15);
    check("R11 irq enabled", {7'b0, uf_irq}, 8'h01);
    wr(3'd3, 8'h02);
    check("R12 underflow cleared", {7'b0, uf_irq}, 8'h00);

    // R3 deep capacity, R7 disable clears overrun
    wr(3'd2, 8'h13);
    for (int i = 0; i < 17; i++) send(8'h10 + 8'(i));
    rd(3'd4, d); check("R3 deep capacity", d, 8'h10);
    wr(3'd2, 8'h12);
    rd(3'd0, d); check("R7 overrun cleared by disable", d, 8'h04);
    send(8'h77);
    rd(3'd4, d); check("R8 count unchanged", d, 8'h10);

    // R10 flush
    wr(3'd2, 8'h1A);
    rd(3'd4, d); check("R10 count zero", d, 8'h00);
    rd(3'd0, d); check("R10 empty", d, 8'h02);
    wr(3'd2, 8'h13);
    send(8'h99);
    take("R10 fresh byte after flush");

    finish_run();
  end
endmodule